// File: doc/BRIEF.md
# Link Error Statistics and Interrupt Register Bank

This block is a small memory-mapped register bank that sits beside a serial link controller. It keeps two error statistics counters. The first counts received packets that the receive path flagged for a failed CRC, sequence or length check. The second counts how many times the transmit side started error recovery and replayed packets. Each counter holds at its all-ones value instead of wrapping. A read returns the count and clears the counter in the same access.

The bank also collects a vector of interrupt sources into sticky status bits. Software clears these bits by writing ones to them. Software also controls one enable bit for each source and a single global gate. The interrupt line comes from a register. It is high only while the global gate is set and at least one latched source is also enabled.

Software reaches the bank through a plain 32-bit port with byte addresses. A read pulse returns its data one clock later. A write pulse takes effect at the clock edge.

Top module: `err_stat_csr`

## Requirements
- R1: After synchronous reset, both counters, the global gate, the enable bits, the status bits, the read data and the interrupt output are all zero.
- R2: Each cycle with `rx_err_pulse` high adds one to the local counter. The local counter reads back at byte address 0x30 in bits CNT_W-1:0. All higher read bits are zero.
- R3: Each cycle with `retry_start_pulse` high adds one to the remote counter. The remote counter reads back at byte address 0x34 in bits CNT_W-1:0. All higher read bits are zero.
- R4: A counter at its all-ones value (0xFFFF for CNT_W=16) stays there when more increments arrive. It never wraps to zero.
- R5: A read of 0x30 or 0x34 puts the current count on `csr_rdata` one cycle after the read pulse. The read also clears that counter to zero.
- R6: When an increment arrives in the same cycle as a read of its counter, the read returns the old value and the counter is left at 1.
- R7: Bit 0 at byte address 0x20 is the read/write global interrupt gate. Write data bits 31:1 are dropped and read back as zero. While the gate is 0, `irq_out` is low.
- R8: The low NUM_SRC bits at 0x24 are per-source enables. Bit i enables source i. `irq_out` is high only when the gate is 1 and some status bit has its enable bit set.
- R9: A high `irq_src[i]` sets status bit i at 0x28. The bit stays set after the source drops. Writing 1 to bit i at 0x28 clears it and writing 0 leaves it alone. A source that is high in the same cycle as the clear wins, so the bit stays set.
- R10: `irq_out` is registered. It changes one clock after the status, enable or gate state that drives it.
- R11: Writes to 0x30 and 0x34 are ignored. A read of any byte address other than 0x20, 0x24, 0x28, 0x30 and 0x34, aligned or not, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 8 | Byte address of the access |
| csr_wr | input | 1 | Write pulse |
| csr_wdata | input | 32 | Write data |
| csr_rd | input | 1 | Read pulse; a counter read also clears that counter |
| csr_rdata | output | 32 | Read data, valid the cycle after the read pulse, held until the next read |
| rx_err_pulse | input | 1 | One received packet failed CRC, sequence or length check |
| retry_start_pulse | input | 1 | Transmit error recovery started |
| irq_src | input | NUM_SRC | Interrupt source levels |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with CNT_W=4 and NUM_SRC=3. A 4-bit counter saturates at 15, so each counter can be swept from zero to past saturation, one run length at a time, in a few hundred cycles. Three sources allow an exhaustive pass over every gate value, every enable mask and every source pattern, with the expected interrupt level worked out arithmetically in the bench. The bench also reads every one of the 256 byte addresses once from a known state.

// File: rtl/errstat_pkg.sv
package errstat_pkg;

    localparam int CSR_AW = 8;
    localparam int CSR_DW = 32;

    localparam logic [CSR_AW-1:0] OFS_IRQ_GATE   = 8'h20;
    localparam logic [CSR_AW-1:0] OFS_IRQ_ENABLE = 8'h24;
    localparam logic [CSR_AW-1:0] OFS_IRQ_STATUS = 8'h28;
    localparam logic [CSR_AW-1:0] OFS_CNT_LOCAL  = 8'h30;
    localparam logic [CSR_AW-1:0] OFS_CNT_REMOTE = 8'h34;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_GATE,
        SEL_ENABLE,
        SEL_STATUS,
        SEL_LOCAL,
        SEL_REMOTE
    } csr_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        csr_sel_e          sel;
        logic [CSR_DW-1:0] wdata;
    } csr_req_t;

    function automatic csr_sel_e decode_addr(input logic [CSR_AW-1:0] addr);
        case (addr)
            OFS_IRQ_GATE:   return SEL_GATE;
            OFS_IRQ_ENABLE: return SEL_ENABLE;
            OFS_IRQ_STATUS: return SEL_STATUS;
            OFS_CNT_LOCAL:  return SEL_LOCAL;
            OFS_CNT_REMOTE: return SEL_REMOTE;
            default:        return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/errstat_decode.sv
module errstat_decode
    import errstat_pkg::*;
(
    input  logic [CSR_AW-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [CSR_DW-1:0] wdata_i,
    output csr_req_t          req_o
);

    always_comb begin
        req_o.sel   = decode_addr(addr_i);
        req_o.wr    = wr_i;
        req_o.rd    = rd_i;
        req_o.wdata = wdata_i;
    end

endmodule

// File: rtl/errstat_satcnt.sv
module errstat_satcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= inc_i ? CNT_ONE : '0;
        end else if (inc_i && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    assign cnt_o = cnt_q;

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        ($past(cnt_q) == CNT_MAX && !$past(clr_i)) |-> (cnt_q == CNT_MAX)); // R4
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !inc_i) |=> (cnt_q == '0)); // R5
    AST_READ_KEEPS_EVENT: assert property (@(posedge clk) disable iff (rst)
        (clr_i && inc_i) |=> (cnt_q == CNT_ONE)); // R6
    AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_ONE)); // R2

endmodule

// File: rtl/errstat_irq.sv
module errstat_irq #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               gate_wr_i,
    input  logic               gate_wdata_i,
    input  logic               en_wr_i,
    input  logic [NUM_SRC-1:0] en_wdata_i,
    input  logic               w1c_wr_i,
    input  logic [NUM_SRC-1:0] w1c_mask_i,
    output logic               gate_o,
    output logic [NUM_SRC-1:0] en_o,
    output logic [NUM_SRC-1:0] st_o,
    output logic               irq_o
);

    logic               gate_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] st_q;
    logic               irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
            en_q   <= '0;
        end else begin
            if (gate_wr_i) gate_q <= gate_wdata_i;
            if (en_wr_i)   en_q   <= en_wdata_i;
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic clr_hit;
        assign clr_hit = w1c_wr_i && w1c_mask_i[i];

        always_ff @(posedge clk) begin
            if (rst)           st_q[i] <= 1'b0;
            else if (src_i[i]) st_q[i] <= 1'b1;
            else if (clr_hit)  st_q[i] <= 1'b0;
        end

        AST_SOURCE_LATCHES: assert property (@(posedge clk) disable iff (rst)
            src_i[i] |=> st_q[i]); // R9
        AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
            (st_q[i] && !w1c_wr_i) |=> st_q[i]); // R9
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= gate_q && |(st_q & en_q);
    end

    assign gate_o = gate_q;
    assign en_o   = en_q;
    assign st_o   = st_q;
    assign irq_o  = irq_q;

    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst)
        !$past(gate_q) |-> !irq_q); // R7
    AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q & en_q) == '0) |-> !irq_q); // R8

endmodule

// File: rtl/err_stat_csr.sv
module err_stat_csr
    import errstat_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         csr_addr,
    input  logic               csr_wr,
    input  logic [31:0]        csr_wdata,
    input  logic               csr_rd,
    output logic [31:0]        csr_rdata,
    input  logic               rx_err_pulse,
    input  logic               retry_start_pulse,
    input  logic [NUM_SRC-1:0] irq_src,
    output logic               irq_out
);

    localparam int CNT_PAD = CSR_DW - CNT_W;
    localparam int SRC_PAD = CSR_DW - NUM_SRC;

    csr_req_t           req;
    logic [CNT_W-1:0]   cnt_local;
    logic [CNT_W-1:0]   cnt_remote;
    logic               gate;
    logic [NUM_SRC-1:0] en;
    logic [NUM_SRC-1:0] st;
    logic [CSR_DW-1:0]  rd_val;
    logic [CSR_DW-1:0]  rdata_q;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^req.wdata[CSR_DW-1:NUM_SRC];

    errstat_decode u_decode (
        .addr_i  (csr_addr),
        .wr_i    (csr_wr),
        .rd_i    (csr_rd),
        .wdata_i (csr_wdata),
        .req_o   (req)
    );

    errstat_satcnt #(.CNT_W(CNT_W)) u_cnt_local (
        .clk   (clk),
        .rst   (rst),
        .inc_i (rx_err_pulse),
        .clr_i (req.rd && req.sel == SEL_LOCAL),
        .cnt_o (cnt_local)
    );

    errstat_satcnt #(.CNT_W(CNT_W)) u_cnt_remote (
        .clk   (clk),
        .rst   (rst),
        .inc_i (retry_start_pulse),
        .clr_i (req.rd && req.sel == SEL_REMOTE),
        .cnt_o (cnt_remote)
    );

    errstat_irq #(.NUM_SRC(NUM_SRC)) u_irq (
        .clk          (clk),
        .rst          (rst),
        .src_i        (irq_src),
        .gate_wr_i    (req.wr && req.sel == SEL_GATE),
        .gate_wdata_i (req.wdata[0]),
        .en_wr_i      (req.wr && req.sel == SEL_ENABLE),
        .en_wdata_i   (req.wdata[NUM_SRC-1:0]),
        .w1c_wr_i     (req.wr && req.sel == SEL_STATUS),
        .w1c_mask_i   (req.wdata[NUM_SRC-1:0]),
        .gate_o       (gate),
        .en_o         (en),
        .st_o         (st),
        .irq_o        (irq_out)
    );

    always_comb begin
        case (req.sel)
            SEL_GATE:   rd_val = {{(CSR_DW-1){1'b0}}, gate};
            SEL_ENABLE: rd_val = {{SRC_PAD{1'b0}}, en};
            SEL_STATUS: rd_val = {{SRC_PAD{1'b0}}, st};
            SEL_LOCAL:  rd_val = {{CNT_PAD{1'b0}}, cnt_local};
            SEL_REMOTE: rd_val = {{CNT_PAD{1'b0}}, cnt_remote};
            default:    rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (req.rd) rdata_q <= rd_val;
    end

    assign csr_rdata = rdata_q;

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (csr_rd && decode_addr(csr_addr) == SEL_NONE) |=> (csr_rdata == '0)); // R11
    AST_COUNTER_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (csr_rd && (csr_addr == OFS_CNT_LOCAL || csr_addr == OFS_CNT_REMOTE))
        |=> (csr_rdata[CSR_DW-1:CNT_W] == '0)); // R2

endmodule

// File: tb/err_stat_csr_tb_top.sv
`timescale 1ns/1ps
module err_stat_csr_tb_top;

    localparam int CNT_W   = 4;
    localparam int NUM_SRC = 3;
    localparam int CMAX    = (1 << CNT_W) - 1;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [7:0]         csr_addr = '0;
    logic               csr_wr = 1'b0;
    logic [31:0]        csr_wdata = '0;
    logic               csr_rd = 1'b0;
    logic [31:0]        csr_rdata;
    logic               rx_err_pulse = 1'b0;
    logic               retry_start_pulse = 1'b0;
    logic [NUM_SRC-1:0] irq_src = '0;
    logic               irq_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] v;

    always #10 clk = ~clk;

    err_stat_csr #(.CNT_W(CNT_W), .NUM_SRC(NUM_SRC)) dut_i (
        .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_wr(csr_wr),
        .csr_wdata(csr_wdata), .csr_rd(csr_rd), .csr_rdata(csr_rdata),
        .rx_err_pulse(rx_err_pulse), .retry_start_pulse(retry_start_pulse),
        .irq_src(irq_src), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
        @(negedge clk); csr_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); csr_addr = a; csr_rd = 1'b1;
        @(negedge clk); csr_rd = 1'b0; d = csr_rdata;
    endtask

    task automatic pulse_local(input int n);
        if (n > 0) begin
            @(negedge clk); rx_err_pulse = 1'b1;
            repeat (n) @(negedge clk);
            rx_err_pulse = 1'b0;
        end
    endtask

    task automatic pulse_remote(input int n);
        if (n > 0) begin
            @(negedge clk); retry_start_pulse = 1'b1;
            repeat (n) @(negedge clk);
            retry_start_pulse = 1'b0;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 irq", {31'b0, irq_out}, 0);
        chk("R1 rdata", csr_rdata, 0);
        rd(8'h30, v); chk("R1 local", v, 0);
        rd(8'h34, v); chk("R1 remote", v, 0);
        rd(8'h20, v); chk("R1 gate", v, 0);
        rd(8'h24, v); chk("R1 enable", v, 0);
        rd(8'h28, v); chk("R1 status", v, 0);

        // R2 R4 R5 local sweep past saturation
        for (int n = 0; n <= CMAX + 3; n++) begin
            pulse_local(n);
            rd(8'h30, v); chk("R2/R4 local count", v, (n > CMAX) ? CMAX : n);
            rd(8'h30, v); chk("R5 local cleared", v, 0);
        end
        // R3 R4 R5 remote sweep
        for (int n = 0; n <= CMAX + 3; n++) begin
            pulse_remote(n);
            rd(8'h34, v); chk("R3/R4 remote count", v, (n > CMAX) ? CMAX : n);
            rd(8'h34, v); chk("R5 remote cleared", v, 0);
        end

        // R6 read together with increment, normal and saturated
        for (int k = 0; k < 2; k++) begin
            int pre = (k == 0) ? 5 : CMAX + 2;
            pulse_local(pre);
            @(negedge clk); csr_addr = 8'h30; csr_rd = 1'b1; rx_err_pulse = 1'b1;
            @(negedge clk); csr_rd = 1'b0; rx_err_pulse = 1'b0;
            chk("R6 old value", csr_rdata, (pre > CMAX) ? CMAX : pre);
            rd(8'h30, v); chk("R6 left at one", v, 1);
            pulse_remote(pre);
            @(negedge clk); csr_addr = 8'h34; csr_rd = 1'b1; retry_start_pulse = 1'b1;
            @(negedge clk); csr_rd = 1'b0; retry_start_pulse = 1'b0;
            chk("R6 remote old value", csr_rdata, (pre > CMAX) ? CMAX : pre);
            rd(8'h34, v); chk("R6 remote left at one", v, 1);
        end

        // R11 writes to counters ignored
        pulse_local(3);
        wr(8'h30, 32'h0);
        rd(8'h30, v); chk("R11 local write ignored", v, 3);
        wr(8'h34, 32'hFFFF_FFFF);
        rd(8'h34, v); chk("R11 remote write ignored", v, 0);

        // R7 only bit 0 of the gate register
        wr(8'h20, 32'hFFFF_FFFE);
        rd(8'h20, v); chk("R7 gate bit0 only", v, 0);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, v); chk("R7 gate set", v, 1);

        // R7 R8 R9 R10 exhaustive gate x enable x source pattern
        for (int g = 0; g < 2; g++) begin
            for (int e = 0; e < (1 << NUM_SRC); e++) begin
                for (int p = 0; p < (1 << NUM_SRC); p++) begin
                    wr(8'h28, 32'hFFFF_FFFF);
                    wr(8'h24, e);
                    wr(8'h20, g);
                    @(negedge clk); irq_src = p[NUM_SRC-1:0];
                    @(negedge clk); irq_src = '0;
                    chk("R10 irq one cycle late", {31'b0, irq_out}, 0);
                    @(negedge clk);
                    chk("R7/R8 irq level", {31'b0, irq_out},
                        ((g == 1) && ((e & p) != 0)) ? 1 : 0);
                    rd(8'h28, v); chk("R9 status latched", v, p);
                    rd(8'h24, v); chk("R8 enable readback", v, e);
                end
            end
        end

        // R9 partial clear and source-wins-over-clear
        wr(8'h28, 32'hFFFF_FFFF);
        @(negedge clk); irq_src = '1;
        @(negedge clk); irq_src = '0;
        wr(8'h28, 32'h2);
        rd(8'h28, v); chk("R9 partial w1c", v, 5);
        wr(8'h28, 32'hFFFF_FFFF);
        @(negedge clk); irq_src = 3'b001; csr_addr = 8'h28; csr_wdata = 32'h1; csr_wr = 1'b1;
        @(negedge clk); irq_src = '0; csr_wr = 1'b0;
        rd(8'h28, v); chk("R9 source wins over clear", v, 1);
        wr(8'h28, 32'h1);
        rd(8'h28, v); chk("R9 clear", v, 0);

        // R11 sweep of all byte addresses from a known state
        wr(8'h20, 32'h1);
        wr(8'h24, 32'h5);
        @(negedge clk); irq_src = 3'b011;
        @(negedge clk); irq_src = '0;
        pulse_local(2);
        pulse_remote(7);
        for (int a = 0; a < 256; a++) begin
            logic [31:0] exp;
            case (a)
                'h20: exp = 1;
                'h24: exp = 5;
                'h28: exp = 3;
                'h30: exp = 2;
                'h34: exp = 7;
                default: exp = 0;
            endcase
            rd(a[7:0], v); chk("R11 address sweep", v, exp);
        end
        // R10 irq with gate 1, enable 5, status 3 -> source 0 enabled
        chk("R10 irq held", {31'b0, irq_out}, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule